// File: doc/BRIEF.md
# Multidrop UART address-filtering receiver

This block is the receive side of a serial port on a shared multidrop line. It runs on a clock at sixteen times the bit rate. It finds start bits, votes on three samples near the middle of each bit, and rebuilds characters of 5 to 8 data bits. Each character carries one extra bit that marks it as a station address or as ordinary data.

Every finished character goes through a filter with two selectable behaviours. In the automatic behaviour, address characters are compared with two programmable station addresses. Only data that follows a matching address is passed on, tagged with which address matched. In the pass-all behaviour, every character is delivered, and each address character opens a new buffer. A hunt command makes the receiver discard traffic until the line has been idle for one character time. A close command starts a new buffer at once, with no wait for idle.

The output is a one-cycle valid strobe with the character, its address flag, a match identity, a start-of-buffer flag and a framing-error flag.

Top module: `mdrop_uart_rx`

## Requirements
- R1: A frame is a low start bit, then the data bits LSB first, then one address bit (1 = address, 0 = data), then a stop bit. Each bit lasts 16 clocks, and its value is the majority of three samples taken near mid-bit.
- R2: A start bit whose mid-bit majority is high is a false start. No character is delivered from it.
- R3: `char_len_i` sets the number of data bits: 0, 1, 2 and 3 select 5, 6, 7 and 8. Data bits above the selected length are delivered as zero.
- R4: With `auto_mode_i` high, an address character is compared only with bits [7:0] of `addr_a_i` and of `addr_b_i`. Bits [15:8] have no effect. The address character itself is not delivered, and data characters after a match are delivered.
- R5: `out_match_o` is 0 for data accepted under a match with `addr_a_i` and 1 for a match with `addr_b_i`. When both match, A wins.
- R6: In the automatic behaviour, an address character that matches neither value drops all following data characters until the next matching address character.
- R7: With `auto_mode_i` low, every character is delivered. `out_is_addr_o` marks address characters, and every address character has `out_sob_o` set.
- R8: `out_sob_o` is set on the first character delivered after reset, after a hunt or close command, and, in the automatic behaviour, on the first data character after a matching address.
- R9: A stop bit sampled low sets `out_ferr_o` for that character, and the character is still delivered.
- R10: After reset or a `hunt_cmd_i` pulse, `hunting_o` is high and finished characters are discarded. The state ends after (data bits + 3) × 16 consecutive clocks of high line. A hunt also returns the automatic filter to discarding.
- R11: A `close_cmd_i` pulse sets `out_sob_o` on the next delivered character. It drops no characters and does not wait for an idle line.
- R12: Each delivered character gives exactly one single-cycle `out_valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| char_len_i | input | 2 | Data bits minus 5 |
| auto_mode_i | input | 1 | 1 = automatic address filtering, 0 = pass all |
| addr_a_i | input | 16 | First station address, bits [7:0] used |
| addr_b_i | input | 16 | Second station address, bits [7:0] used |
| hunt_cmd_i | input | 1 | Pulse: enter hunt, wait for idle line |
| close_cmd_i | input | 1 | Pulse: end current buffer |
| out_valid_o | output | 1 | Character delivered this cycle |
| out_data_o | output | 8 | Received character, unused MSBs zero |
| out_is_addr_o | output | 1 | Character is an address character |
| out_match_o | output | 1 | Matched address: 0 = A, 1 = B |
| out_sob_o | output | 1 | Character starts a new buffer |
| out_ferr_o | output | 1 | Stop bit was low |
| hunting_o | output | 1 | Receiver waiting for idle line |

## Verification
The hardest states to reach from the ports are in the automatic behaviour: the discard state after an unmatched address, and the discard state left behind by a hunt once the idle wait is over. Both depend on history across several frames and on how long the line stays high. The stimulus builds frame sequences with short gaps that never add up to an idle character time. It inserts a full idle gap only where the hunt is meant to end. It then sends data both before and after a fresh matching address, so that the drop and the resume can each be seen.

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx #(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  input  logic [1:0]  char_len_i,
  input  logic        auto_mode_i,
  input  logic [15:0] addr_a_i,
  input  logic [15:0] addr_b_i,
  input  logic        hunt_cmd_i,
  input  logic        close_cmd_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  output logic        out_is_addr_o,
  output logic        out_match_o,
  output logic        out_sob_o,
  output logic        out_ferr_o,
  output logic        hunting_o
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 + 1;
  localparam int IW  = $clog2(11 * OVS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ADR, S_STOP} st_t;

  logic [1:0]    sync_q;
  logic [2:0]    vote_q;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    sr;
  logic          adb;
  logic [IW-1:0] idle_q;
  logic          hunt_q, pass_q, id_q, nb_q;

  wire          rx_s   = sync_q[1];
  wire          maj    = (vote_q[0] & vote_q[1]) | (vote_q[0] & vote_q[2]) | (vote_q[1] & vote_q[2]);
  wire [3:0]    nbits  = {2'b00, char_len_i} + 4'd5;
  wire          mid    = cnt == CW'(MID);
  wire          last   = cnt == CW'(OVS - 1);
  wire          done   = (st == S_STOP) && mid;
  wire [IW-1:0] idle_lim = IW'((32'(nbits) + 32'd3) * OVS);
  wire          hit_a  = sr == addr_a_i[7:0];
  wire          hit_b  = sr == addr_b_i[7:0];
  wire          unused_hi = ^{addr_a_i[15:8], addr_b_i[15:8]};

  assign hunting_o = hunt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      vote_q <= 3'b111;
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sr     <= '0;
      adb    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      vote_q <= {vote_q[1:0], rx_s};
      cnt    <= (st == S_IDLE || last) ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE:  if (!rx_s) begin st <= S_START; sr <= '0; end
        S_START: if (mid && maj) st <= S_IDLE;
                 else if (last) begin st <= S_DATA; bidx <= '0; end
        S_DATA: begin
          if (mid) sr[bidx] <= maj;
          if (last) begin
            if ({1'b0, bidx} == nbits - 4'd1) st <= S_ADR;
            else bidx <= bidx + 1'b1;
          end
        end
        S_ADR: begin
          if (mid) adb <= maj;
          if (last) st <= S_STOP;
        end
        S_STOP:  if (mid) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      hunt_q <= 1'b1;
    end else begin
      if (hunt_cmd_i || !rx_s) idle_q <= '0;
      else if (idle_q < idle_lim) idle_q <= idle_q + 1'b1;
      if (hunt_cmd_i) hunt_q <= 1'b1;
      else if (idle_q >= idle_lim) hunt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pass_q        <= 1'b0;
      id_q          <= 1'b0;
      nb_q          <= 1'b1;
      out_valid_o   <= 1'b0;
      out_data_o    <= '0;
      out_is_addr_o <= 1'b0;
      out_match_o   <= 1'b0;
      out_sob_o     <= 1'b0;
      out_ferr_o    <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      if (done && !hunt_q && !hunt_cmd_i) begin
        if (auto_mode_i && adb) begin
          pass_q <= hit_a | hit_b;
          if (hit_a | hit_b) begin
            id_q <= !hit_a;
            nb_q <= 1'b1;
          end
        end else if (!auto_mode_i || pass_q) begin
          out_valid_o   <= 1'b1;
          out_data_o    <= sr;
          out_is_addr_o <= adb;
          out_match_o   <= auto_mode_i ? id_q : 1'b0;
          out_sob_o     <= nb_q | adb;
          out_ferr_o    <= !maj;
          nb_q          <= 1'b0;
        end
      end
      if (close_cmd_i) nb_q <= 1'b1;
      if (hunt_cmd_i) begin
        nb_q   <= 1'b1;
        pass_q <= 1'b0;
      end
    end
  end

  p_addr_sob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_is_addr_o |-> out_sob_o);

  p_auto_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && auto_mode_i |-> !out_is_addr_o);

  p_hunt_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_q |=> !out_valid_o);

  p_short_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && char_len_i != 2'd3 |-> out_data_o[7] == 1'b0);

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);
endmodule

// File: tb/sim_mdrop_uart_rx.sv
module sim_mdrop_uart_rx;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic [1:0] clen = 2'd3;
  logic amode = 1'b0, hunt = 1'b0, close = 1'b0;
  logic [15:0] ra = 16'h0, rb = 16'h0;
  logic ov, oa, om, osob, ofe, hunting;
  logic [7:0] od;
  int total = 0, bad = 0;

  logic [11:0] exp_q[$];
  string tag_q[$];
  bit m_hunt = 1, m_pass = 0, m_id = 0, m_nb = 1;

  always #2 clk = ~clk;

  mdrop_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .char_len_i(clen), .auto_mode_i(amode),
    .addr_a_i(ra), .addr_b_i(rb), .hunt_cmd_i(hunt), .close_cmd_i(close),
    .out_valid_o(ov), .out_data_o(od), .out_is_addr_o(oa), .out_match_o(om),
    .out_sob_o(osob), .out_ferr_o(ofe), .hunting_o(hunting));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ov) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected character", {20'h0, od, oa, om, osob, ofe}, 32'h0);
      else begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({od, oa, om, osob, ofe} == e, t, {20'h0, od, oa, om, osob, ofe}, {20'h0, e});
      end
    end
  end

  function automatic int nlen();
    return int'(clen) + 5;
  endfunction

  task automatic bitv(input logic v);
    rx = v;
    repeat (16) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic adb, input logic stopb, input string tag);
    logic [7:0] dm;
    logic ha, hb;
    bit dlv;
    logic [11:0] e;
    dm = d & 8'((1 << nlen()) - 1);
    dlv = 0;
    e = '0;
    if (!m_hunt) begin
      if (amode && adb) begin
        ha = dm == ra[7:0];
        hb = dm == rb[7:0];
        m_pass = ha | hb;
        if (ha | hb) begin m_id = !ha; m_nb = 1; end
      end else if (!amode || m_pass) begin
        dlv = 1;
        e = {dm, adb, amode ? m_id : 1'b0, m_nb | adb, !stopb};
        m_nb = 0;
      end
    end
    if (dlv) begin exp_q.push_back(e); tag_q.push_back(tag); end
    bitv(1'b0);
    for (int i = 0; i < nlen(); i++) bitv(d[i]);
    bitv(adb);
    bitv(stopb);
    rx = 1'b1;
    repeat (32) @(negedge clk);
  endtask

  task automatic idle_wait();
    repeat ((nlen() + 3) * 16 + 8) @(negedge clk);
    m_hunt = 0;
    chk(hunting == 1'b0, "R10 hunt ends after idle", {31'h0, hunting}, 32'h0);
  endtask

  task automatic do_hunt();
    hunt = 1'b1; @(negedge clk); hunt = 1'b0;
    m_hunt = 1; m_nb = 1; m_pass = 0;
    @(negedge clk);
    chk(hunting == 1'b1, "R10 hunting after command", {31'h0, hunting}, 32'h1);
  endtask

  task automatic do_close();
    close = 1'b1; @(negedge clk); close = 1'b0;
    m_nb = 1;
  endtask

  task automatic run();
    repeat (3) @(negedge clk);
    chk(ov == 1'b0, "R12 reset valid low", {31'h0, ov}, 32'h0);
    chk(hunting == 1'b1, "R10 reset hunting", {31'h0, hunting}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h55, 1'b0, 1'b1, "R10 dropped while hunting");
    idle_wait();
    send(8'h12, 1'b1, 1'b1, "R7 address delivered with sob");
    send(8'hA5, 1'b0, 1'b1, "R1 data after address");
    send(8'h3C, 1'b0, 1'b1, "R1 second data");
    do_close();
    send(8'h77, 1'b0, 1'b1, "R11 sob after close");
    send(8'h01, 1'b0, 1'b1, "R8 sob cleared");
    send(8'h0F, 1'b0, 1'b0, "R9 framing error flagged");
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (64) @(negedge clk);
    send(8'h80, 1'b0, 1'b1, "R2 false start ignored, next char ok");
    clen = 2'd0;
    send(8'hFF, 1'b0, 1'b1, "R3 5-bit char MSBs zero");
    clen = 2'd1;
    send(8'hC3, 1'b0, 1'b1, "R3 6-bit char");
    clen = 2'd3;
    amode = 1'b1; ra = 16'hAB12; rb = 16'h0034;
    send(8'h11, 1'b0, 1'b1, "R6 data before any match dropped");
    send(8'h12, 1'b1, 1'b1, "R4 address A");
    send(8'h21, 1'b0, 1'b1, "R4 data after A, sob");
    send(8'h22, 1'b0, 1'b1, "R5 id A");
    send(8'h34, 1'b1, 1'b1, "R5 address B");
    send(8'h31, 1'b0, 1'b1, "R5 id B with sob");
    send(8'h99, 1'b1, 1'b1, "R6 unmatched address");
    send(8'h41, 1'b0, 1'b1, "R6 dropped after mismatch");
    send(8'h34, 1'b1, 1'b1, "R6 rematch");
    send(8'h42, 1'b0, 1'b1, "R6 resume after rematch");
    rb = 16'h0012;
    send(8'h12, 1'b1, 1'b1, "R5 both match");
    send(8'h51, 1'b0, 1'b1, "R5 A wins tie");
    do_hunt();
    send(8'h61, 1'b0, 1'b1, "R10 drop during hunt");
    idle_wait();
    send(8'h62, 1'b0, 1'b1, "R10 filter discarding after hunt");
    send(8'h12, 1'b1, 1'b1, "R10 address after hunt");
    send(8'h63, 1'b0, 1'b1, "R8 data after hunt and match");
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all expected delivered", exp_q.size(), 32'h0);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule